// File: doc/BRIEF.md
# Ten-Way Johnson Divider with One-Hot Decode

This block divides its clock by ten. The count is kept in a five-bit twisted-ring (Johnson) shift register. A small decoder turns that register into ten count lines, and exactly one of them is high for each count. Two adjacent ring bits are enough to identify each count, so every decoded line is a two-input AND of register bits. The ring also has a third-state guard: if the register ever holds a pattern outside the legal ten-state loop, the next enabled edge sends it back to count zero.

A carry line is also produced. It is high for the first half of the cycle and low for the second half, which gives a square wave at one tenth of the input rate. It rises exactly when the count wraps from nine to zero. An active-high hold input freezes the count. An active-high clear resets the count to zero at once, without waiting for a clock edge. Several blocks can be chained into a larger decimal divider. One way is to clock the next stage from the carry. The other is to keep a shared clock and hold the next stage except while this stage shows count nine. There is no data stream and no handshake: every pin is a plain control or status line.

Top module: `johnson_decade`

## Requirements
- R1: While `clr` is high, `count_hot` equals 10'b00_0000_0001 (bit 0 = count zero) and `carry_out` is 1. This takes effect without any clock edge.
- R2: On each rising `clk` edge with `hold` low and `clr` low, the count advances by one (bit k of `count_hot` moves to bit k+1), and count 9 wraps to count 0.
- R3: While `hold` is high at a rising edge, the count and `carry_out` keep their values.
- R4: Outside of clear and outside illegal ring states, exactly one bit of `count_hot` is high.
- R5: `carry_out` is 1 for counts 0 to 4 and 0 for counts 5 to 9. It rises only on the edge that moves the count from 9 to 0.
- R6: `clr` takes priority over `clk` and `hold`. Clock edges that arrive while `clr` is high leave the count at 0, whatever the value of `hold`.
- R7: If the ring register holds any illegal five-bit pattern, the next rising edge with `hold` low loads count 0.
- R8: Two instances can be cascaded on one clock by driving the upper stage's `hold` with the lower `hold` OR'd with the inverse of the lower `count_hot[9]`. The pair then counts 0 to 99, with the upper stage stepping once per ten lower counts.
- R9: The outputs depend only on the registered ring state. A change on `hold` between edges does not change `count_hot` or `carry_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge active |
| clr | input | 1 | Asynchronous clear to count 0, active high |
| hold | input | 1 | Count inhibit, active high |
| count_hot | output | 10 | One-hot decoded count, bit k high at count k |
| count_hot | output | 10 | One-hot decoded count, bit k high at count k |
| carry_out | output | 1 | Divide-by-ten square wave, high for counts 0 to 4 |

## Verification
The counting path is driven by a vector table that mixes runs of free counting with hold cycles placed at different counts. It also includes a full wrap through count 9 and clear pulses given with hold both low and high. This shows whether the advance, the hold and the clear priority are correct. Directed cases then check the following:
- a clear raised between edges, to confirm it acts asynchronously;
- a hold toggled between edges, to confirm the outputs are purely registered;
- an injected illegal ring pattern, to confirm recovery;
- a two-stage cascade sampled at counts 37, 50 and 100, which checks carry phase and the step timing of the upper stage.

// File: rtl/johnson_pkg.sv
package johnson_pkg;
  parameter int unsigned DEF_STAGES = 5;

  typedef enum logic [1:0] {
    RA_HOLD   = 2'd0,
    RA_SHIFT  = 2'd1,
    RA_RESYNC = 2'd2
  } ring_act_e;
endpackage

// File: rtl/johnson_ring.sv
module johnson_ring
  import johnson_pkg::*;
#(
  parameter int unsigned STAGES = DEF_STAGES
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              hold,
  output logic [STAGES-1:0] ring_q,
  output logic              ring_bad
);
  localparam int unsigned EDGES = STAGES - 1;

  logic [STAGES-1:0] state_q;
  logic [STAGES-1:0] state_d;
  logic [EDGES-1:0]  boundary;
  ring_act_e         act;

  // A legal Johnson word has at most one boundary between neighbouring bits.
  always_comb begin
    for (int i = 0; i < int'(EDGES); i++) begin
      boundary[i] = state_q[i+1] ^ state_q[i];
    end
  end

  assign ring_bad = ($countones(boundary) > 1);

  always_comb begin
    if (hold)          act = RA_HOLD;
    else if (ring_bad) act = RA_RESYNC;
    else               act = RA_SHIFT;
  end

  always_comb begin
    unique case (act)
      RA_SHIFT:  state_d = {state_q[STAGES-2:0], ~state_q[STAGES-1]};
      RA_RESYNC: state_d = '0;
      default:   state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) state_q <= '0;
    else     state_q <= state_d;
  end

  assign ring_q = state_q;

  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (clr) hold |=> $stable(state_q)); // R3
  AST_RESYNC_ZERO: assert property (@(posedge clk) disable iff (clr) (!hold && ring_bad) |=> (state_q == '0)); // R7
endmodule

// File: rtl/johnson_decode.sv
module johnson_decode #(
  parameter int unsigned STAGES = johnson_pkg::DEF_STAGES
) (
  input  logic [STAGES-1:0]   ring_q,
  output logic [2*STAGES-1:0] hot
);
  localparam int unsigned COUNTS = 2 * STAGES;

  for (genvar k = 0; k < COUNTS; k++) begin : g_tap
    if (k == 0) begin : g_zero
      assign hot[k] = ~ring_q[0] & ~ring_q[STAGES-1];
    end else if (k < STAGES) begin : g_fill
      assign hot[k] = ring_q[k-1] & ~ring_q[k];
    end else if (k == STAGES) begin : g_full
      assign hot[k] = ring_q[0] & ring_q[STAGES-1];
    end else begin : g_drain
      assign hot[k] = ~ring_q[k-STAGES-1] & ring_q[k-STAGES];
    end
  end
endmodule

// File: rtl/johnson_decade.sv
module johnson_decade
  import johnson_pkg::*;
#(
  parameter int unsigned STAGES = DEF_STAGES
) (
  input  logic                clk,
  input  logic                clr,
  input  logic                hold,
  output logic [2*STAGES-1:0] count_hot,
  output logic                carry_out
);
  localparam int unsigned COUNTS = 2 * STAGES;
  localparam int unsigned LAST   = COUNTS - 1;

  logic [STAGES-1:0] ring_q;
  logic              ring_bad;

  johnson_ring #(.STAGES(STAGES)) u_ring (
    .clk      (clk),
    .clr      (clr),
    .hold     (hold),
    .ring_q   (ring_q),
    .ring_bad (ring_bad)
  );

  johnson_decode #(.STAGES(STAGES)) u_dec (
    .ring_q (ring_q),
    .hot    (count_hot)
  );

  // Last stage is low for the first half of the cycle.
  assign carry_out = ~ring_q[STAGES-1];

  always @(posedge clk) begin
    if (clr) begin
      AST_CLEAR_ZERO: assert (count_hot == COUNTS'(1) && carry_out); // R1
    end
  end

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (clr || ring_bad) $onehot(count_hot)); // R4
  AST_WRAP: assert property (@(posedge clk) disable iff (clr) (!hold && !ring_bad && count_hot[LAST]) |=> count_hot[0]); // R2
  AST_CARRY_RISE: assert property (@(posedge clk) disable iff (clr) $rose(carry_out) |-> count_hot[0]); // R5
  AST_CARRY_HALF: assert property (@(posedge clk) disable iff (clr || ring_bad) carry_out == (|count_hot[STAGES-1:0])); // R5
endmodule

// File: tb/tb_johnson_decade.sv
`timescale 1ns/1ps
module tb_johnson_decade;
  localparam int NV = 17;

  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       hold = 1'b0;
  logic [9:0] count_hot;
  logic       carry_out;
  logic       hi_hold;
  logic [9:0] hi_hot;
  logic       hi_carry;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;

  always #4 clk = ~clk;

  johnson_decade dut (
    .clk(clk), .clr(clr), .hold(hold), .count_hot(count_hot), .carry_out(carry_out)
  );

  assign hi_hold = hold | ~count_hot[9];

  johnson_decade u_hi (
    .clk(clk), .clr(clr), .hold(hi_hold), .count_hot(hi_hot), .carry_out(hi_carry)
  );

  // {clr, hold, expected count after the edge}
  localparam logic [5:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd1}, {1'b0, 1'b0, 4'd2}, {1'b0, 1'b1, 4'd2}, {1'b0, 1'b0, 4'd3},
    {1'b0, 1'b0, 4'd4}, {1'b0, 1'b0, 4'd5}, {1'b0, 1'b1, 4'd5}, {1'b0, 1'b0, 4'd6},
    {1'b0, 1'b0, 4'd7}, {1'b0, 1'b0, 4'd8}, {1'b0, 1'b0, 4'd9}, {1'b0, 1'b0, 4'd0},
    {1'b0, 1'b0, 4'd1}, {1'b1, 1'b0, 4'd0}, {1'b1, 1'b1, 4'd0}, {1'b0, 1'b1, 4'd0},
    {1'b0, 1'b0, 4'd1}
  };

  task automatic check_count(input string req, input logic [9:0] act_hot, input logic act_c,
                             input int exp_idx);
    logic [9:0] eh;
    logic       ec;
    eh = 10'(1) << exp_idx;
    ec = (exp_idx < 5);
    vectors++;
    if (act_hot !== eh || act_c !== ec) begin
      misses++;
      $display("FAIL %s: hot=%b carry=%b expected hot=%b carry=%b", req, act_hot, act_c, eh, ec);
    end
  endtask

  task automatic step(input logic c, input logic h);
    @(negedge clk);
    clr  = c;
    hold = h;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      vectors++;
      misses++;
      $display("FAIL watchdog: cycles=%0d expected below 200000", cycles);
      finish_run();
    end
  end

  initial begin
    #3;
    check_count("R1 reset state", count_hot, carry_out, 0);
    repeat (2) @(posedge clk);
    #1;
    check_count("R6 edges during clear", count_hot, carry_out, 0);
    step(1'b0, 1'b0);
    check_count("R2 first count after clear", count_hot, carry_out, 1);
    step(1'b1, 1'b0);

    // The table starts from count 0.
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][5], VEC[i][4]);
      check_count(VEC[i][5] ? "R6 clear vector" : (VEC[i][4] ? "R3 hold vector" : "R2 count vector"),
                  count_hot, carry_out, int'(VEC[i][3:0]));
    end

    // R1: asynchronous clear between edges (count now 1)
    step(1'b0, 1'b0);
    @(negedge clk);
    #1 clr = 1'b1;
    #1 check_count("R1 async clear", count_hot, carry_out, 0);
    step(1'b0, 1'b0);
    check_count("R2 count after async clear", count_hot, carry_out, 1);

    // R3: long hold
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1);
    check_count("R3 long hold", count_hot, carry_out, 1);

    // R9: hold toggling between edges leaves outputs alone
    @(negedge clk);
    hold = 1'b0;
    #1 check_count("R9 hold low between edges", count_hot, carry_out, 1);
    hold = 1'b1;
    #1 check_count("R9 hold high between edges", count_hot, carry_out, 1);

    // R5: carry falls at 5, rises on wrap
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
    check_count("R5 carry low at count 5", count_hot, carry_out, 5);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
    check_count("R5 carry low at count 9", count_hot, carry_out, 9);
    step(1'b0, 1'b0);
    check_count("R5 carry rises on wrap", count_hot, carry_out, 0);

    // R7: illegal ring pattern recovers on next enabled edge
    @(negedge clk);
    hold = 1'b0;
    force dut.u_ring.state_q = 5'b01010;
    #1 release dut.u_ring.state_q;
    @(posedge clk);
    #1 check_count("R7 recovery from illegal pattern", count_hot, carry_out, 0);

    // R8: two-stage cascade
    step(1'b1, 1'b0);
    for (int i = 0; i < 37; i++) step(1'b0, 1'b0);
    check_count("R8 cascade low digit at 37", count_hot, carry_out, 7);
    check_count("R8 cascade high digit at 37", hi_hot, hi_carry, 3);
    for (int i = 0; i < 13; i++) step(1'b0, 1'b0);
    check_count("R8 cascade high digit at 50", hi_hot, hi_carry, 5);
    for (int i = 0; i < 50; i++) step(1'b0, 1'b0);
    check_count("R8 cascade low digit at 100", count_hot, carry_out, 0);
    check_count("R8 cascade high digit at 100", hi_hot, hi_carry, 0);

    finish_run();
  end
endmodule